// File: doc/BRIEF.md
# SDRAM Read-Burst Precharge Scheduler

This block sits inside an SDRAM controller, between the request queue and the command pins. It accepts one read request at a time: a bank, a column, a burst shape (a fixed burst of `BURST_LEN` words or an open-ended full-page burst), a CAS latency of 1, 2 or 3, the number of words the requester actually needs, an auto-precharge flag and a flag that widens the closing precharge to every bank. It issues the READ and marks the cycles in which wanted data arrives. It then closes the row with a PRECHARGE timed so that the last wanted word still comes out, which cuts the burst short when fewer words are needed.

The closing command goes out (CAS latency − 1) cycles before the edge that carries the last wanted word. Because that word lands CAS latency cycles after its column slot, the PRECHARGE falls exactly `span` cycles after the READ for every latency setting. Here `span` is the number of wanted words, capped at the burst length for fixed bursts. Each bank keeps its own row-precharge hold-off of `TRP` cycles and reports when a new ACTIVE may be requested. An ACTIVE request that arrives earlier is refused silently, so the caller simply holds it until it is taken.

Top module: `rdpre_sched`

## Requirements
- R1: After reset `cmd` is NOP (encoding: 0 NOP, 1 ACTIVE, 2 READ, 3 PRECHARGE), `rd_valid`, `req_err` and `busy` are low and every `bank_ready` bit is high. Any cycle with nothing to issue shows NOP.
- R2: A valid request sampled while `busy` is low shows READ on `cmd` in the next cycle (called T0), with `cmd_bank` equal to the request bank, the column in the low bits of `cmd_addr` and `cmd_addr[10]` equal to the auto-precharge flag.
- R3: `rd_valid` is high exactly in cycles T(CL) to T(CL+span−1) and low otherwise. `span` is the wanted count for a full-page burst and min(wanted, `BURST_LEN`) for a fixed burst.
- R4: Without auto precharge, PRECHARGE appears in cycle T(span) for every CAS latency. It carries the read bank on `cmd_bank`, the all-bank flag on `cmd_addr[10]`, and zero in the other address bits.
- R5: With auto precharge on a fixed burst of at least `BURST_LEN` wanted words, no PRECHARGE command is issued. The bank hold-off runs exactly as if one had been issued at T(`BURST_LEN`).
- R6: ACTIVE opens a bank and drops its `bank_ready`. A precharge at T(p) makes `bank_ready` of its target (every bank when the all-bank flag is set) rise in cycle T(p+TRP−1). An ACTIVE request held from then on shows ACTIVE with the request bank and row in cycle T(p+TRP), and never earlier.
- R7: A request with zero wanted words, CAS latency 0, or auto precharge combined with a full-page burst or with fewer than `BURST_LEN` wanted words is rejected. `req_err` pulses in the following cycle, and no command and no data strobe result.
- R8: A request presented while `busy` is high is ignored: no command, no error, and the burst in progress keeps its timing.
- R9: An ACTIVE request for a bank whose `bank_ready` is low, or while a read is being scheduled, produces no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_bank | input | BA_W | Bank of the read |
| req_col | input | COL_W | Start column |
| req_page | input | 1 | 1 selects a full-page burst, 0 a fixed burst of BURST_LEN |
| req_want | input | WANT_W | Number of data words wanted |
| req_auto | input | 1 | Auto precharge requested with the READ |
| req_all | input | 1 | Closing precharge targets all banks |
| cas_lat | input | 2 | CAS latency, 1 to 3 |
| act_req | input | 1 | ACTIVE request |
| act_bank | input | BA_W | Bank to open |
| act_row | input | ROW_W | Row to open |
| cmd | output | 2 | Command: 0 NOP, 1 ACTIVE, 2 READ, 3 PRECHARGE |
| cmd_bank | output | BA_W | Bank of the command |
| cmd_addr | output | ROW_W | Address of the command (bit 10 is the auto / all flag) |
| rd_valid | output | 1 | A wanted data word is valid in this cycle |
| bank_ready | output | NBANK | ACTIVE to this bank would be taken now |
| req_err | output | 1 | The previous cycle's request was rejected |
| busy | output | 1 | A read is being scheduled or its data is still due |

## Verification
Every CAS latency is combined with fixed bursts cut short, run exactly to length and asked for more than the burst holds, with full-page bursts of several lengths, and with auto-precharged fixed bursts. Together these separate a truncating precharge from a completing one and show that its cycle does not depend on the latency. Holding an ACTIVE request from the READ onward reveals the first cycle the hold-off allows. The all-bank variant shows that every bank is released together. Malformed requests and a request pushed in during a running burst show that they are rejected or ignored and leave the timing alone.

// File: rtl/rdpre_pkg.sv
// Package: shared command encoding for the read precharge scheduler.
// Assumes a two-bit command bus decoded by the SDRAM pin driver.
package rdpre_pkg;
    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_ACT  = 2'd1,
        CMD_READ = 2'd2,
        CMD_PRE  = 2'd3
    } cmd_e;
endpackage

// File: rtl/rdpre_engine.sv
// rdpre_engine: accepts one read request, checks its shape, and counts
// cycles from the READ slot to the closing precharge slot (span cycles).
// Assumes the caller registers the next-command outputs; data_busy keeps
// a new read out until the previous one's data has drained.
module rdpre_engine
    import rdpre_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int COL_W     = 8,
    parameter int ADDR_W    = 12,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4,
    parameter int WANT_W    = 9,
    localparam int BA_W     = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_page,
    input  logic [WANT_W-1:0] req_want,
    input  logic              req_auto,
    input  logic              req_all,
    input  logic [1:0]        cas_lat,
    input  logic              data_busy,
    output logic              idle,
    output logic              accept,
    output logic              reject,
    output logic [WANT_W-1:0] span,
    output cmd_e              nxt_cmd,
    output logic [BA_W-1:0]   nxt_bank,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              pre_evt,
    output logic              pre_all,
    output logic [BA_W-1:0]   pre_bank
);
    localparam logic [WANT_W-1:0] BL_V = WANT_W'(BURST_LEN);

    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    st_e               st_q;
    logic [WANT_W-1:0] k_q, s_q;
    logic              auto_q, all_q;
    logic [BA_W-1:0]   bank_q;
    logic              bad, avail, last;

    // Request shape: wanted span and the rejection rule.
    always_comb begin
        span  = req_page ? req_want : ((req_want > BL_V) ? BL_V : req_want);
        bad   = (req_want == '0) || (cas_lat == 2'd0) ||
                (req_auto && (req_page || (req_want < BL_V)));
        idle  = (st_q == ST_IDLE);
        avail = idle && !data_busy && req_valid;
        accept = avail && !bad;
        reject = avail && bad;
        last  = (st_q == ST_RUN) && ((k_q + WANT_W'(1)) == s_q);
        pre_evt  = last;
        pre_all  = all_q;
        pre_bank = bank_q;
    end

    // Next command slot: READ on accept, PRECHARGE at the closing slot.
    always_comb begin
        nxt_cmd  = CMD_NOP;
        nxt_bank = '0;
        nxt_addr = '0;
        if (accept) begin
            nxt_cmd          = CMD_READ;
            nxt_bank         = req_bank;
            nxt_addr         = ADDR_W'(req_col);
            nxt_addr[AP_BIT] = req_auto;
        end else if (last && !auto_q) begin
            nxt_cmd          = CMD_PRE;
            nxt_bank         = bank_q;
            nxt_addr[AP_BIT] = all_q;
        end
    end

    // Sequencer: latch the request and count up to the closing slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            k_q    <= '0;
            s_q    <= '0;
            auto_q <= 1'b0;
            all_q  <= 1'b0;
            bank_q <= '0;
        end else if (st_q == ST_IDLE) begin
            if (accept) begin
                st_q   <= ST_RUN;
                k_q    <= '0;
                s_q    <= span;
                auto_q <= req_auto;
                all_q  <= req_all && !req_auto;
                bank_q <= req_bank;
            end
        end else begin
            k_q <= k_q + WANT_W'(1);
            if (last) st_q <= ST_IDLE;
        end
    end
endmodule

// File: rtl/rdpre_strobe.sv
// rdpre_strobe: marks the cycles in which wanted read data is valid.
// Assumes start pulses at the edge that issues READ; the strobe is high
// from CL to CL+span-1 cycles after the READ cycle, then drops.
module rdpre_strobe #(
    parameter int WANT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        cl,
    input  logic [WANT_W-1:0] span,
    output logic              active,
    output logic              rd_valid
);
    logic [WANT_W:0]   j_q, end_v;
    logic [1:0]        cl_q;
    logic [WANT_W-1:0] s_q;

    // Window bounds taken from the latched latency and span.
    always_comb begin
        end_v    = {1'b0, s_q} + (WANT_W+1)'(cl_q);
        rd_valid = active && (j_q >= (WANT_W+1)'(cl_q));
    end

    // Cycle counter from the READ cycle to the end of the data window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            j_q    <= '0;
            cl_q   <= '0;
            s_q    <= '0;
        end else if (start) begin
            active <= 1'b1;
            j_q    <= '0;
            cl_q   <= cl;
            s_q    <= span;
        end else if (active) begin
            j_q <= j_q + (WANT_W+1)'(1);
            if ((j_q + (WANT_W+1)'(1)) == end_v) active <= 1'b0;
        end
    end
endmodule

// File: rtl/rdpre_bank_tmr.sv
// rdpre_bank_tmr: per-bank open flag and row precharge hold-off.
// ready means an ACTIVE request taken at the coming edge respects TRP,
// so it rises one cycle before TRP has fully elapsed. Assumes TRP >= 1.
module rdpre_bank_tmr #(
    parameter int NBANK = 4,
    parameter int TRP   = 3,
    localparam int BA_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int TRP_W = $clog2(TRP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_evt,
    input  logic [BA_W-1:0]  act_bank,
    input  logic             pre_evt,
    input  logic             pre_all,
    input  logic [BA_W-1:0]  pre_bank,
    output logic [NBANK-1:0] ready
);
    localparam logic [TRP_W-1:0] TRP_V = TRP_W'(TRP);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic             open_q;
        logic [TRP_W-1:0] tmr_q;

        // Bank state: opened by ACTIVE, closed and timed by precharge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                tmr_q  <= '0;
            end else if (pre_evt && (pre_all || (pre_bank == BA_W'(b)))) begin
                open_q <= 1'b0;
                tmr_q  <= TRP_V;
            end else begin
                if (act_evt && (act_bank == BA_W'(b))) open_q <= 1'b1;
                if (tmr_q != '0) tmr_q <= tmr_q - TRP_W'(1);
            end
        end

        assign ready[b] = !open_q && (tmr_q <= TRP_W'(1));
    end
endmodule

// File: rtl/rdpre_sched.sv
// rdpre_sched: read-burst precharge scheduler. Issues READ, places the
// closing PRECHARGE (CL-1) cycles before the last wanted data edge, strobes
// wanted data and gates ACTIVE by a per-bank row precharge hold-off.
// Assumes one read in flight at a time and a registered command bus.
module rdpre_sched
    import rdpre_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int COL_W     = 8,
    parameter int ROW_W     = 12,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4,
    parameter int WANT_W    = 9,
    parameter int TRP       = 3,
    localparam int BA_W     = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_page,
    input  logic [WANT_W-1:0] req_want,
    input  logic              req_auto,
    input  logic              req_all,
    input  logic [1:0]        cas_lat,
    input  logic              act_req,
    input  logic [BA_W-1:0]   act_bank,
    input  logic [ROW_W-1:0]  act_row,
    output logic [1:0]        cmd,
    output logic [BA_W-1:0]   cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic              rd_valid,
    output logic [NBANK-1:0]  bank_ready,
    output logic              req_err,
    output logic              busy
);
    logic              eng_idle, accept, reject, pre_evt, pre_all, act_fire;
    logic              data_busy;
    logic [WANT_W-1:0] span;
    cmd_e              nxt_cmd;
    logic [BA_W-1:0]   nxt_bank, pre_bank;
    logic [ROW_W-1:0]  nxt_addr;
    cmd_e              cmd_q;
    logic [BA_W-1:0]   bank_q;
    logic [ROW_W-1:0]  addr_q;
    logic              err_q;

    rdpre_engine #(
        .NBANK(NBANK), .COL_W(COL_W), .ADDR_W(ROW_W), .AP_BIT(AP_BIT),
        .BURST_LEN(BURST_LEN), .WANT_W(WANT_W)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_col(req_col), .req_page(req_page), .req_want(req_want),
        .req_auto(req_auto), .req_all(req_all), .cas_lat(cas_lat),
        .data_busy(data_busy), .idle(eng_idle), .accept(accept),
        .reject(reject), .span(span), .nxt_cmd(nxt_cmd), .nxt_bank(nxt_bank),
        .nxt_addr(nxt_addr), .pre_evt(pre_evt), .pre_all(pre_all),
        .pre_bank(pre_bank)
    );

    rdpre_strobe #(.WANT_W(WANT_W)) u_stb (
        .clk(clk), .rst_n(rst_n), .start(accept), .cl(cas_lat), .span(span),
        .active(data_busy), .rd_valid(rd_valid)
    );

    rdpre_bank_tmr #(.NBANK(NBANK), .TRP(TRP)) u_tmr (
        .clk(clk), .rst_n(rst_n), .act_evt(act_fire), .act_bank(act_bank),
        .pre_evt(pre_evt), .pre_all(pre_all), .pre_bank(pre_bank),
        .ready(bank_ready)
    );

    // ACTIVE is taken only when the command slot is free and the bank is clear.
    assign act_fire = act_req && eng_idle && !req_valid && bank_ready[act_bank];

    // Command register: ACTIVE or the engine's READ / PRECHARGE / NOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= reject;
            if (act_fire) begin
                cmd_q  <= CMD_ACT;
                bank_q <= act_bank;
                addr_q <= act_row;
            end else begin
                cmd_q  <= nxt_cmd;
                bank_q <= nxt_bank;
                addr_q <= nxt_addr;
            end
        end
    end

    assign cmd      = cmd_q;
    assign cmd_bank = bank_q;
    assign cmd_addr = addr_q;
    assign req_err  = err_q;
    assign busy     = !eng_idle || data_busy;
endmodule

// File: rtl/rdpre_sched_chk.sv
// rdpre_sched_chk: protocol checker bound to rdpre_sched. Tracks cycles
// since the last precharge per bank and the previous cycle's ready flags.
module rdpre_sched_chk #(
    parameter int NBANK  = 4,
    parameter int ROW_W  = 12,
    parameter int TRP    = 3,
    localparam int BA_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cmd,
    input logic [BA_W-1:0]  cmd_bank,
    input logic [ROW_W-1:0] cmd_addr,
    input logic             rd_valid,
    input logic [NBANK-1:0] bank_ready,
    input logic             req_err
);
    localparam int AP = 10;

    logic [7:0]       since_q [NBANK];
    logic [NBANK-1:0] prev_ready_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_since
        // Cycles since the last precharge that covered this bank (saturating).
        always_ff @(posedge clk) begin
            if (!rst_n)
                since_q[b] <= 8'hFF;
            else if ((cmd == 2'd3) && (cmd_addr[AP] || (cmd_bank == BA_W'(b))))
                since_q[b] <= 8'd1;
            else if (since_q[b] != 8'hFF)
                since_q[b] <= since_q[b] + 8'd1;
        end
    end

    // Ready flags as seen one cycle earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_ready_q <= '0;
        else        prev_ready_q <= bank_ready;
    end

    assert_act_after_trp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1) |-> (int'(since_q[cmd_bank]) >= TRP));

    assert_act_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1) |-> prev_ready_q[cmd_bank]);

    assert_read_bus_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd2) |-> !rd_valid);

    assert_reject_no_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (cmd == 2'd0));

    assert_pre_not_repeated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd3) |=> (cmd != 2'd3));
endmodule

bind rdpre_sched rdpre_sched_chk #(.NBANK(NBANK), .ROW_W(ROW_W), .TRP(TRP)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .rd_valid(rd_valid), .bank_ready(bank_ready),
    .req_err(req_err)
);

// File: tb/sim_rdpre_sched.sv
`timescale 1ns/1ps
// sim_rdpre_sched: sweeps CAS latency, burst shape and wanted count, and
// compares every cycle of command, strobe and ready against arithmetic.
module sim_rdpre_sched;
    localparam int NB  = 4;
    localparam int BL  = 4;
    localparam int TRP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_bank = '0;
    logic [7:0] req_col = '0;
    logic       req_page = 1'b0;
    logic [8:0] req_want = '0;
    logic       req_auto = 1'b0;
    logic       req_all = 1'b0;
    logic [1:0] cas_lat = 2'd1;
    logic       act_req = 1'b0;
    logic [1:0] act_bank = '0;
    logic [11:0] act_row = '0;
    logic [1:0] cmd;
    logic [1:0] cmd_bank;
    logic [11:0] cmd_addr;
    logic       rd_valid;
    logic [3:0] bank_ready;
    logic       req_err;
    logic       busy;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    bit bopen [NB];

    always #2.5 clk = ~clk;

    rdpre_sched #(
        .NBANK(NB), .COL_W(8), .ROW_W(12), .AP_BIT(10), .BURST_LEN(BL),
        .WANT_W(9), .TRP(TRP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_col(req_col), .req_page(req_page), .req_want(req_want),
        .req_auto(req_auto), .req_all(req_all), .cas_lat(cas_lat),
        .act_req(act_req), .act_bank(act_bank), .act_row(act_row),
        .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .rd_valid(rd_valid), .bank_ready(bank_ready), .req_err(req_err),
        .busy(busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int row_of(input int bank);
        return 12'h100 + bank * 37 + 5;
    endfunction

    // One complete read with hold-off probe; cycle j counts from the READ cycle.
    task automatic run_read(input int cl, input int page, input int want, input int autop,
                            input int allb, input int bank, input int col, input int intrude);
        int s;
        int last;
        s = page ? want : ((want > BL) ? BL : want);
        if (!bopen[bank]) begin
            for (int w = 0; w < 20 && !bank_ready[bank]; w++) @(negedge clk);
            act_req = 1'b1; act_bank = 2'(bank); act_row = 12'(row_of(bank));
            @(negedge clk);
            act_req = 1'b0;
            chk("R6", "open cmd", int'(cmd), 1);
            chk("R6", "ready after open", int'(bank_ready[bank]), 0);
            bopen[bank] = 1;
        end
        for (int w = 0; w < 50 && busy; w++) @(negedge clk);
        req_valid = 1'b1; req_bank = 2'(bank); req_col = 8'(col); req_page = page[0];
        req_want = 9'(want); req_auto = autop[0]; req_all = allb[0]; cas_lat = 2'(cl);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "read cmd", int'(cmd), 2);
        chk("R2", "read bank", int'(cmd_bank), bank);
        chk("R2", "read addr", int'(cmd_addr), col | (autop << 10));
        chk("R3", "strobe at T0", int'(rd_valid), 0);
        act_req = 1'b1; act_bank = 2'(bank); act_row = 12'(row_of(bank));
        if (intrude != 0) begin
            req_valid = 1'b1; req_bank = 2'((bank + 1) % NB); req_want = 9'd1;
            req_auto = 1'b0; req_page = 1'b0; req_all = 1'b0;
        end
        last = ((cl + s) > (s + TRP)) ? (cl + s + 1) : (s + TRP + 1);
        for (int j = 1; j <= last; j++) begin
            int exp_cmd;
            @(negedge clk);
            exp_cmd = (j == s && autop == 0) ? 3 : ((j == s + TRP) ? 1 : 0);
            if (exp_cmd == 3) begin
                chk("R4", "precharge cmd", int'(cmd), 3);
                chk("R4", "precharge bank", int'(cmd_bank), bank);
                chk("R4", "precharge addr", int'(cmd_addr), allb << 10);
            end else if (exp_cmd == 1) begin
                chk("R6", "active after hold-off", int'(cmd), 1);
                chk("R6", "active bank", int'(cmd_bank), bank);
                chk("R6", "active row", int'(cmd_addr), row_of(bank));
            end else if (j == s) begin
                chk("R5", "no precharge with auto", int'(cmd), 0);
            end else begin
                chk("R9", "idle slot while active refused", int'(cmd), 0);
            end
            chk("R3", "data strobe", int'(rd_valid), int'(j >= cl && j < cl + s));
            chk(autop != 0 ? "R5" : "R6", "bank ready", int'(bank_ready[bank]),
                int'(j == s + TRP - 1));
            if (allb != 0 && j == s + TRP - 1)
                chk("R4", "all banks ready", int'(bank_ready), 15);
            if (intrude != 0)
                chk("R8", "no error for busy request", int'(req_err), 0);
            if (j == s + TRP) act_req = 1'b0;
            if (intrude != 0 && j == 1) req_valid = 1'b0;
        end
        act_req = 1'b0;
        if (allb != 0) for (int b = 0; b < NB; b++) bopen[b] = 0;
        bopen[bank] = 1;
    endtask

    // A malformed request: error pulse, no command, no data.
    task automatic run_bad(input int cl, input int page, input int want, input int autop);
        for (int w = 0; w < 50 && busy; w++) @(negedge clk);
        req_valid = 1'b1; req_bank = 2'd2; req_col = 8'h11; req_page = page[0];
        req_want = 9'(want); req_auto = autop[0]; req_all = 1'b0; cas_lat = 2'(cl);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7", "error pulse", int'(req_err), 1);
        chk("R7", "no command on reject", int'(cmd), 0);
        for (int j = 1; j <= 4; j++) begin
            @(negedge clk);
            chk("R7", "quiet after reject", int'(cmd), 0);
            chk("R7", "no strobe after reject", int'(rd_valid), 0);
            chk("R7", "not busy after reject", int'(busy), 0);
            if (j == 1) chk("R7", "error is one pulse", int'(req_err), 0);
        end
    endtask

    initial begin
        for (int b = 0; b < NB; b++) bopen[b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset cmd", int'(cmd), 0);
        chk("R1", "reset strobe", int'(rd_valid), 0);
        chk("R1", "reset ready", int'(bank_ready), 15);
        chk("R1", "reset error", int'(req_err), 0);
        chk("R1", "reset busy", int'(busy), 0);
        for (int cl = 1; cl <= 3; cl++)
            for (int mode = 0; mode < 3; mode++)
                for (int want = 1; want <= 9; want++) begin
                    if (mode == 1 && want < BL) continue;
                    run_read(cl, int'(mode == 2), want, int'(mode == 1),
                             int'((want % 4 == 3) && mode != 1), (want + cl) % NB,
                             (want * 13 + cl * 5) & 255, int'(cl == 2 && want == 2));
                end
        run_bad(0, 0, 4, 0);
        run_bad(2, 0, 0, 0);
        run_bad(2, 0, 2, 1);
        run_bad(3, 1, 8, 1);
        run_bad(1, 1, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule